// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block chooses one interrupt for a small CPU out of five request lines: external 0, timer 0 overflow, external 1, timer 1 overflow, and serial transmit/receive. Each line is gated twice. A master enable gates all lines, and each line also has its own enable bit. Each line is then placed at either a high or a low level by a one-bit priority setting. The block presents a single request to the CPU, together with the winning source index and its vector address.

Two in-service flip-flops track which level the CPU is currently handling. A running low-level handler can be preempted by a high-level request. A running high-level handler cannot be preempted. When several requests at one level are pending together, a fixed order picks the winner.

An acknowledge from the CPU marks the winner's level as in service. One cycle later it pulses a clear to that source's request flag, but only for sources configured for hardware clearing. A return strobe closes the innermost handler. Software reads and writes the enable and priority settings through a small address/data port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every priority bit reads 0, `irq_o` is 0, `flag_clr_o` is 0, and neither level is in service.
- R2: A write with `reg_wr_i`=1 to address 0 stores the master enable from bit 7 and the source enables from bits 4:0. A write to address 1 stores the source priorities from bits 4:0 (1 = high, 0 = low). Reads return the stored bits in the same positions, and every other bit reads 0.
- R3: While the master enable is 0, `irq_o` stays 0 whatever the requests are.
- R4: While the master enable is 1, a source whose own enable bit is 0 is never presented.
- R5: Within one level, the lowest pending source index wins. The indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. `irq_src_o` carries the winning index.
- R6: While `irq_o` is 1, `irq_vec_o` equals 8 × `irq_src_o` + 3. This gives 0x03, 0x0B, 0x13, 0x1B and 0x23.
- R7: When no handler is active, any eligible high-level request wins over every eligible low-level request, regardless of index.
- R8: `ack_i` while `irq_o` is 1 marks the winner's level in service. In the next cycle, `flag_clr_o` has exactly the winner's bit set, provided that bit of `HW_CLR_MASK` is 1. The default mask is 5'b01111, so serial is not cleared by hardware.
- R9: While only the low level is in service, only high-level requests are presented.
- R10: While the high level is in service, `irq_o` stays 0.
- R11: `reti_i` clears the high in-service flag if it is set, and otherwise clears the low one.
- R12: `ack_i` while `irq_o` is 0 changes no state and produces no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Pending request flags, index 0..4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 enables, 1 priorities |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| reti_i | input | 1 | CPU leaves the current handler |
| irq_o | output | 1 | Interrupt presented to the CPU |
| irq_src_o | output | 3 | Index of the presented source |
| irq_vec_o | output | 8 | Vector address of the presented source |
| flag_clr_o | output | 5 | One-cycle clear pulse to source flags |

## Verification
The hardest state to reach is two handlers nested at once. A low handler must be open and a high handler must be running on top of it. From there, a return must close only the inner handler and leave the outer one still blocking low requests. The stimulus builds this state one step at a time. It places serial at the high level and acknowledges a low external source. It then raises serial and acknowledges it. It then issues two returns and checks, after each one, which requests the controller presents again.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } level_e;

    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile #(
    parameter int NSRC    = 5,
    parameter int DW      = 8,
    parameter int GEN_BIT = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            gen_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] prio_o
);
    typedef struct packed {
        logic            gen;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] prio;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            if (!addr_i) begin
                s_d.gen = wdata_i[GEN_BIT];
                s_d.en  = wdata_i[NSRC-1:0];
            end else begin
                s_d.prio = wdata_i[NSRC-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        if (!addr_i) begin
            rdata_o[NSRC-1:0] = s_q.en;
            rdata_o[GEN_BIT]  = s_q.gen;
        end else begin
            rdata_o[NSRC-1:0] = s_q.prio;
        end
    end

    assign gen_o  = s_q.gen;
    assign en_o   = s_q.en;
    assign prio_o = s_q.prio;

    // R2: bits other than the defined fields never read as 1
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i |-> (rdata_o[DW-1:NSRC] == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NSRC = 5,
    parameter int IDXW = 3,
    parameter int VW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            gen_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            isr_hi_i,
    input  logic            isr_lo_i,
    output logic            valid_o,
    output logic [IDXW-1:0] idx_o,
    output level_e          lvl_o,
    output logic [VW-1:0]   vec_o
);
    logic [NSRC-1:0] elig, cand_hi, cand_lo, pick;

    always_comb begin
        elig    = req_i & en_i & {NSRC{gen_i}};
        cand_hi = elig & prio_i;
        cand_lo = elig & ~prio_i;
        pick    = '0;
        lvl_o   = LVL_NONE;
        if (!isr_hi_i) begin
            if (|cand_hi) begin
                pick  = cand_hi;
                lvl_o = LVL_HIGH;
            end else if (!isr_lo_i && |cand_lo) begin
                pick  = cand_lo;
                lvl_o = LVL_LOW;
            end
        end
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick[i]) idx_o = IDXW'(i);
        end
        valid_o = |pick;
        vec_o   = VW'(VEC_BASE + VEC_STRIDE * int'(idx_o));
    end

    // R5: presented index always names a real, pending source
    a_r5_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(idx_o) < NSRC) && req_i[idx_o]);
    // R6: vector low bits are always 3 on a valid request
    a_r6_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vec_o[2:0] == 3'd3));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC        = 5,
    parameter int DW          = 8,
    parameter int GEN_BIT     = 7,
    parameter int VW          = 8,
    parameter logic [NSRC-1:0] HW_CLR_MASK = 5'b01111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            reg_wr_i,
    input  logic            reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    input  logic            ack_i,
    input  logic            reti_i,
    output logic            irq_o,
    output logic [2:0]      irq_src_o,
    output logic [VW-1:0]   irq_vec_o,
    output logic [NSRC-1:0] flag_clr_o
);
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic            isr_hi;
        logic            isr_lo;
        logic [NSRC-1:0] clr;
    } st_t;

    st_t s_d, s_q;

    logic            gen;
    logic [NSRC-1:0] en, prio;
    logic            win_valid;
    logic [IDXW-1:0] win_idx;
    level_e          win_lvl;
    logic [VW-1:0]   win_vec;

    pic_regfile #(.NSRC(NSRC), .DW(DW), .GEN_BIT(GEN_BIT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .gen_o   (gen),
        .en_o    (en),
        .prio_o  (prio)
    );

    pic_arbiter #(.NSRC(NSRC), .IDXW(IDXW), .VW(VW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .en_i     (en),
        .gen_i    (gen),
        .prio_i   (prio),
        .isr_hi_i (s_q.isr_hi),
        .isr_lo_i (s_q.isr_lo),
        .valid_o  (win_valid),
        .idx_o    (win_idx),
        .lvl_o    (win_lvl),
        .vec_o    (win_vec)
    );

    always_comb begin
        s_d     = s_q;
        s_d.clr = '0;
        if (reti_i) begin
            if (s_q.isr_hi) s_d.isr_hi = 1'b0;
            else            s_d.isr_lo = 1'b0;
        end
        if (ack_i && win_valid) begin
            if (win_lvl == LVL_HIGH) s_d.isr_hi = 1'b1;
            else                     s_d.isr_lo = 1'b1;
            if (HW_CLR_MASK[win_idx]) s_d.clr[win_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o      = win_valid;
    assign irq_src_o  = 3'(win_idx);
    assign irq_vec_o  = win_vec;
    assign flag_clr_o = s_q.clr;

    // R10: nothing is presented while a high handler runs
    a_r10_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.isr_hi |-> !irq_o);
    // R9: with only a low handler open, presented sources are high level
    a_r9_low_open: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.isr_lo && irq_o) |-> prio[irq_src_o]);
    // R3: master enable off masks everything
    a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !irq_o);
    // R8: clear pulse names at most one source
    a_r8_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr_o));
    // R8: an accepted request leaves a level in service
    a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (s_q.isr_hi || s_q.isr_lo));
    // R12: acknowledge with nothing presented produces no clear
    a_r12_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> (flag_clr_o == '0));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req_i = '0;
    logic       reg_wr_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       ack_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       irq_o;
    logic [2:0] irq_src_o;
    logic [7:0] irq_vec_o;
    logic [4:0] flag_clr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o),
        .irq_src_o(irq_src_o), .irq_vec_o(irq_vec_o),
        .flag_clr_o(flag_clr_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = '0; ack_i = 0; reti_i = 0; reg_wr_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr_i = a;
        #1 v = int'(reg_rdata_o);
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic pulse_reti();
        reti_i = 1'b1;
        @(negedge clk);
        reti_i = 1'b0;
    endtask

    task automatic expect_irq(input string tag, input int src);
        check({tag, " irq"}, int'(irq_o), 1);
        check({tag, " src"}, int'(irq_src_o), src);
        check({tag, " vec"}, int'(irq_vec_o), 8 * src + 3);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(1'b0, v); check("R1 enable reg", v, 0);
        rd(1'b1, v); check("R1 prio reg", v, 0);
        req_i = 5'h1F; #1;
        check("R1 irq", int'(irq_o), 0);
        check("R1 clr", int'(flag_clr_o), 0);
    endtask

    task automatic t_regs();
        int v;
        do_reset();
        wr(1'b0, 8'hFF); rd(1'b0, v); check("R2 enable readback", v, 8'h9F);
        wr(1'b1, 8'hFF); rd(1'b1, v); check("R2 prio readback", v, 8'h1F);
        wr(1'b0, 8'h05); rd(1'b0, v); check("R2 enable rewrite", v, 8'h05);
        reg_wdata_i = 8'h00; #1; rd(1'b1, v); check("R2 no write without strobe", v, 8'h1F);
    endtask

    task automatic t_global();
        do_reset();
        wr(1'b0, 8'h1F); req_i = 5'h1F; #1;
        check("R3 master off", int'(irq_o), 0);
        wr(1'b0, 8'h9F); #1;
        expect_irq("R3 master on", 0);
    endtask

    task automatic t_source_en();
        do_reset();
        wr(1'b0, 8'h88); req_i = 5'h1F; #1;
        expect_irq("R4 only timer1 enabled", 3);
        wr(1'b0, 8'h90); req_i = 5'h08; #1;
        check("R4 disabled source", int'(irq_o), 0);
    endtask

    task automatic t_order();
        do_reset();
        wr(1'b0, 8'h9F);
        req_i = 5'h1E; #1; expect_irq("R5 R6 order t0", 1);
        req_i = 5'h1C; #1; expect_irq("R5 R6 order e1", 2);
        req_i = 5'h18; #1; expect_irq("R5 R6 order t1", 3);
        req_i = 5'h10; #1; expect_irq("R5 R6 order serial", 4);
    endtask

    task automatic t_levels();
        do_reset();
        wr(1'b0, 8'h9F); req_i = 5'h1F;
        wr(1'b1, 8'h10); #1; expect_irq("R7 serial high", 4);
        wr(1'b1, 8'h0A); #1; expect_irq("R7 two high, order", 1);
    endtask

    task automatic t_nesting();
        do_reset();
        wr(1'b0, 8'h9F); wr(1'b1, 8'h10);
        req_i = 5'h0F; #1;
        expect_irq("R8 low winner", 0);
        pulse_ack(); #1;
        check("R8 clear pulse ext0", int'(flag_clr_o), 5'h01);
        check("R9 low blocked", int'(irq_o), 0);
        @(negedge clk);
        check("R8 clear one cycle", int'(flag_clr_o), 0);
        req_i = 5'h1F; #1;
        expect_irq("R9 high preempts", 4);
        pulse_ack(); #1;
        check("R8 serial not hw cleared", int'(flag_clr_o), 0);
        check("R10 high blocks all", int'(irq_o), 0);
        pulse_reti(); #1;
        expect_irq("R11 high closed first", 4);
        req_i = 5'h0F; #1;
        check("R11 low still open", int'(irq_o), 0);
        pulse_reti(); #1;
        expect_irq("R11 low closed", 0);
    endtask

    task automatic t_ack_idle();
        do_reset();
        wr(1'b0, 8'h9F);
        req_i = 5'h00; #1;
        pulse_ack(); #1;
        check("R12 no clear on idle ack", int'(flag_clr_o), 0);
        req_i = 5'h04; #1;
        expect_irq("R12 no state from idle ack", 2);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_global();
        t_source_en();
        t_order();
        t_levels();
        t_nesting();
        t_ack_idle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule